// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer arithmetic and logic unit of a small RISC-style core. It takes two operands, a four-bit operation code and the core's current condition flags. After one clock it gives back the result and the new negative, zero, carry and overflow flags, together with a flag-write strobe. A single adder serves six arithmetic forms:

- addition and addition with carry;
- subtraction and subtraction with carry;
- reverse subtraction and reverse subtraction with carry, where the operand order is swapped in front of the adder.

Five bitwise forms make up the rest of the set. They are AND, exclusive OR, inclusive OR, bit-clear and invert-second-operand.

Bitwise forms keep the incoming overflow flag. By default they also keep the incoming carry. When the caller asks for it, they take the carry from an external shifter instead. When the caller does not request a flag update, the old flags come back unchanged, so the flag register can be written from this output every cycle.

Top module: `flag_alu`

## Requirements
- R1: Outputs are registered. The result and flags for inputs presented at one rising clock edge appear after that edge. A synchronous active-high `rst` clears `result`, `flags_out` and `flags_we` to zero.
- R2: Code 0 gives a+b. Code 1 gives a+b+C, where C is `flags_in[1]`. The carry flag is the unsigned carry out of bit W-1.
- R3: Code 2 gives a-b. Code 3 gives a-b+C-1. The carry flag is 1 when no borrow occurs: a >= b for code 2, and a >= b+(1-C) for code 3, both compared unsigned.
- R4: Code 4 gives b-a and code 5 gives b-a+C-1. Their carry and overflow follow R3 and R6 with the operands swapped.
- R5: For codes 0 and 1, the overflow flag is set when both operands have the same sign and the result sign differs from it.
- R6: For codes 2 and 3, the overflow flag is set when the operands differ in sign and the result sign differs from the first operand.
- R7: The bitwise codes compute: 6 gives a AND b, 7 gives a XOR b, 8 gives a OR b, 9 gives a AND NOT b, and 10 gives NOT b. Codes 11 to 15 give a zero result and behave as bitwise codes for the flags.
- R8: When flags are updated, N (`flags_out[3]`) is the result's top bit and Z (`flags_out[2]`) is 1 exactly when the result is zero. This holds for all codes.
- R9: For bitwise codes, V (`flags_out[0]`) equals `flags_in[0]`. C (`flags_out[1]`) equals `shift_c` when `shift_c_sel` is 1, and `flags_in[1]` otherwise.
- R10: When `set_flags` is 0, `flags_out` equals the `flags_in` of the same operation and `flags_we` is 0. When `set_flags` is 1, `flags_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_sel | input | 4 | Operation code |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Request a flag update |
| shift_c_sel | input | 1 | Bitwise codes take carry from `shift_c` |
| shift_c | input | 1 | Carry produced by the external shifter |
| result | output | W | Registered result |
| flags_out | output | 4 | Registered flags {N,Z,C,V} |
| flags_we | output | 1 | Registered flag-write strobe |

## Verification
The assertions check the following on every cycle:

- the flag-write strobe and the pass-through of old flags when no update is requested;
- N and Z against the registered result;
- that bitwise codes keep V and pick C from the proper source;
- the sum produced by plain addition.

The carry-in chained forms, the no-borrow carry on subtraction, the operand swap of the reverse forms and both signed-overflow rules can only be shown by the bench's scenarios. Those scenarios compare every result against an independent wide-integer model, including at the signed and unsigned boundaries.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_RSB = 4'd4,
    OP_RSC = 4'd5,
    OP_AND = 4'd6,
    OP_EOR = 4'd7,
    OP_ORR = 4'd8,
    OP_BIC = 4'd9,
    OP_MVN = 4'd10
  } alu_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  function automatic logic op_is_arith(input logic [3:0] op);
    return op <= OP_RSC;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         do_sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] y_eff;
  logic [W:0]   total;
  logic [W-1:0] same_sign;

  // Subtraction adds the inverted operand; the carry-in supplies the +1.
  assign y_eff     = do_sub ? ~y_in : y_in;
  assign total     = {1'b0, x_in} + {1'b0, y_eff} + {{W{1'b0}}, cin};
  assign sum       = total[W-1:0];
  assign cout      = total[W];
  assign same_sign = ~(x_in ^ y_in);
  assign ovf       = do_sub ? ((x_in[W-1] ^ y_in[W-1]) & (x_in[W-1] ^ sum[W-1]))
                            : (same_sign[W-1] & (x_in[W-1] ^ sum[W-1]));
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_EOR:  y = a ^ b;
      OP_ORR:  y = a | b;
      OP_BIC:  y = a & ~b;
      OP_MVN:  y = ~b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         arith,
  input  logic         upd,
  input  logic [W-1:0] res,
  input  logic         add_c,
  input  logic         add_v,
  input  logic [3:0]   old_flags,
  input  logic         sc_sel,
  input  logic         sc,
  output logic [3:0]   new_flags
);
  logic c_logic;

  assign c_logic = sc_sel ? sc : old_flags[FLG_C];

  always_comb begin
    new_flags = old_flags;
    if (upd) begin
      new_flags[FLG_N] = res[W-1];
      new_flags[FLG_Z] = (res == '0);
      new_flags[FLG_C] = arith ? add_c : c_logic;
      new_flags[FLG_V] = arith ? add_v : old_flags[FLG_V];
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic [3:0]   flags_in,
  input  logic         set_flags,
  input  logic         shift_c_sel,
  input  logic         shift_c,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic         flags_we
);
  logic         arith, swap, do_sub, cin;
  logic [W-1:0] x_op, y_op, sum, bits, res_next;
  logic         add_c, add_v;
  logic [3:0]   flags_next;

  assign arith  = op_is_arith(op_sel);
  assign swap   = (op_sel == OP_RSB) || (op_sel == OP_RSC);
  assign do_sub = (op_sel == OP_SUB) || (op_sel == OP_SBC) || swap;

  // Plain add takes 0, plain subtract takes 1, chained forms take the carry flag.
  always_comb begin
    unique case (op_sel)
      OP_ADD:                 cin = 1'b0;
      OP_SUB, OP_RSB:         cin = 1'b1;
      OP_ADC, OP_SBC, OP_RSC: cin = flags_in[FLG_C];
      default:                cin = 1'b0;
    endcase
  end

  assign x_op = swap ? op_b : op_a;
  assign y_op = swap ? op_a : op_b;

  alu_addsub #(.W(W)) addsub_i (
    .x_in(x_op), .y_in(y_op), .do_sub(do_sub), .cin(cin),
    .sum(sum), .cout(add_c), .ovf(add_v)
  );

  alu_bitwise #(.W(W)) bitwise_i (
    .op(op_sel), .a(op_a), .b(op_b), .y(bits)
  );

  assign res_next = arith ? sum : bits;

  alu_flag_merge #(.W(W)) merge_i (
    .arith(arith), .upd(set_flags), .res(res_next), .add_c(add_c),
    .add_v(add_v), .old_flags(flags_in), .sc_sel(shift_c_sel), .sc(shift_c),
    .new_flags(flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= '0;
      flags_we  <= 1'b0;
    end else begin
      result    <= res_next;
      flags_out <= flags_next;
      flags_we  <= set_flags;
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   op_sel,
  input logic [3:0]   flags_in,
  input logic         set_flags,
  input logic         shift_c_sel,
  input logic         shift_c,
  input logic [W-1:0] result,
  input logic [3:0]   flags_out,
  input logic         flags_we
);
  logic primed = 1'b0;

  always_ff @(posedge clk) primed <= !rst;

  // R10: strobe follows the request
  p_we_follow_r10: assert property (@(posedge clk) disable iff (rst || !primed)
    flags_we == $past(set_flags));

  // R10: no update returns the old flags
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst || !primed)
    !$past(set_flags) |-> flags_out == $past(flags_in));

  // R8: zero flag tracks the registered result
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(set_flags) |-> flags_out[2] == (result == '0));

  // R8: negative flag tracks the registered result
  p_neg_flag_r8: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(set_flags) |-> flags_out[3] == result[W-1]);

  // R9: bitwise codes keep V
  p_logic_keeps_v_r9: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(set_flags) && $past(op_sel) >= 4'd6) |-> flags_out[0] == $past(flags_in[0]));

  // R9: bitwise carry source
  p_logic_carry_r9: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(set_flags) && $past(op_sel) >= 4'd6) |->
      flags_out[1] == ($past(shift_c_sel) ? $past(shift_c) : $past(flags_in[1])));

  // R2: plain addition sum
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op_sel) == 4'd0) |-> result == $past(op_a) + $past(op_b));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .flags_in(flags_in), .set_flags(set_flags), .shift_c_sel(shift_c_sel),
  .shift_c(shift_c), .result(result), .flags_out(flags_out), .flags_we(flags_we)
);

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [3:0]   op_sel = '0, flags_in = '0;
  logic         set_flags = 1'b0, shift_c_sel = 1'b0, shift_c = 1'b0;
  logic [W-1:0] result;
  logic [3:0]   flags_out;
  logic         flags_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  flag_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flags_in(flags_in), .set_flags(set_flags), .shift_c_sel(shift_c_sel),
    .shift_c(shift_c), .result(result), .flags_out(flags_out), .flags_we(flags_we)
  );

  function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] fi, input logic set, input logic usc,
                                input logic sc, output logic [31:0] res, output logic [3:0] fl);
    longint sx, sy, s;
    logic [32:0] ux, uy;
    logic [31:0] x, y;
    logic c, v, brw;
    c = fi[1];
    v = fi[0];
    if (op <= 4'd1) begin
      ux = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? {32'd0, fi[1]} : 33'd0);
      res = ux[31:0];
      c = ux[32];
      s = longint'($signed(a)) + longint'($signed(b)) + ((op == 4'd1) ? longint'(fi[1]) : 0);
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else if (op <= 4'd5) begin
      x = (op >= 4'd4) ? b : a;
      y = (op >= 4'd4) ? a : b;
      brw = (op == 4'd3 || op == 4'd5) ? !fi[1] : 1'b0;
      res = x - y - {31'd0, brw};
      ux = {1'b0, x};
      uy = {1'b0, y} + {32'd0, brw};
      c = (ux >= uy);
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      s = sx - sy - longint'(brw);
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (op)
        4'd6:    res = a & b;
        4'd7:    res = a ^ b;
        4'd8:    res = a | b;
        4'd9:    res = a & ~b;
        4'd10:   res = ~b;
        default: res = 32'd0;
      endcase
      if (usc) c = sc;
    end
    fl = set ? {res[31], res == 32'd0, c, v} : fi;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                        logic [3:0] fi, logic set, logic usc, logic sc);
    logic [31:0] er;
    logic [3:0] ef;
    model(op, a, b, fi, set, usc, sc, er, ef);
    op_sel = op; op_a = a; op_b = b; flags_in = fi;
    set_flags = set; shift_c_sel = usc; shift_c = sc;
    @(negedge clk);
    check(req, "result", result, er);
    check(req, "flags", {28'd0, flags_out}, {28'd0, ef});
    check("R10", "flags_we", {31'd0, flags_we}, {31'd0, set});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op_sel = 4'd7; op_a = 32'hFFFF_0000; op_b = 32'h1234_5678;
    flags_in = 4'hF; set_flags = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "reset result", result, 32'd0);
    check("R1", "reset flags", {28'd0, flags_out}, 32'd0);
    check("R1", "reset we", {31'd0, flags_we}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_add();
    run_op("R2", 4'd0, 32'd5, 32'd7, 4'h0, 1, 0, 0);
    run_op("R2", 4'd0, 32'hFFFF_FFFF, 32'd1, 4'h0, 1, 0, 0);
    run_op("R2", 4'd1, 32'hFFFF_FFFF, 32'd0, 4'h2, 1, 0, 0);
    run_op("R2", 4'd1, 32'd10, 32'd20, 4'h0, 1, 0, 0);
    run_op("R2", 4'd1, 32'h8000_0000, 32'h7FFF_FFFF, 4'h2, 1, 0, 0);
  endtask

  task automatic t_sub();
    run_op("R3", 4'd2, 32'd9, 32'd9, 4'h0, 1, 0, 0);
    run_op("R3", 4'd2, 32'd3, 32'd9, 4'h0, 1, 0, 0);
    run_op("R3", 4'd3, 32'd9, 32'd9, 4'h0, 1, 0, 0);
    run_op("R3", 4'd3, 32'd9, 32'd9, 4'h2, 1, 0, 0);
    run_op("R3", 4'd3, 32'd0, 32'hFFFF_FFFF, 4'h2, 1, 0, 0);
  endtask

  task automatic t_reverse();
    run_op("R4", 4'd4, 32'd3, 32'd10, 4'h0, 1, 0, 0);
    run_op("R4", 4'd4, 32'd10, 32'd3, 4'h0, 1, 0, 0);
    run_op("R4", 4'd5, 32'd4, 32'd4, 4'h0, 1, 0, 0);
    run_op("R4", 4'd5, 32'd1, 32'h8000_0000, 4'h2, 1, 0, 0);
  endtask

  task automatic t_overflow();
    run_op("R5", 4'd0, 32'h7FFF_FFFF, 32'd1, 4'h0, 1, 0, 0);
    run_op("R5", 4'd0, 32'h8000_0000, 32'h8000_0000, 4'h0, 1, 0, 0);
    run_op("R5", 4'd0, 32'h7FFF_FFFF, 32'h8000_0000, 4'h1, 1, 0, 0);
    run_op("R6", 4'd2, 32'h8000_0000, 32'd1, 4'h0, 1, 0, 0);
    run_op("R6", 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    run_op("R6", 4'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'h1, 1, 0, 0);
  endtask

  task automatic t_logic();
    run_op("R7", 4'd6, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'h3, 1, 0, 0);
    run_op("R7", 4'd7, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'h0, 1, 0, 0);
    run_op("R7", 4'd8, 32'h8000_0000, 32'h0000_0001, 4'h0, 1, 0, 0);
    run_op("R7", 4'd9, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'h1, 1, 0, 0);
    run_op("R7", 4'd10, 32'h1234_5678, 32'h0000_0000, 4'h2, 1, 0, 0);
    run_op("R7", 4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h3, 1, 0, 0);
    run_op("R8", 4'd10, 32'd0, 32'hFFFF_FFFF, 4'h8, 1, 0, 0);
  endtask

  task automatic t_shift_carry();
    run_op("R9", 4'd8, 32'd1, 32'd2, 4'h0, 1, 1, 1);
    run_op("R9", 4'd8, 32'd1, 32'd2, 4'h3, 1, 1, 0);
    run_op("R9", 4'd6, 32'd1, 32'd2, 4'h3, 1, 0, 0);
    run_op("R9", 4'd0, 32'd1, 32'd2, 4'h0, 1, 1, 1);
  endtask

  task automatic t_noflags();
    run_op("R10", 4'd2, 32'd0, 32'd0, 4'hA, 0, 0, 0);
    run_op("R10", 4'd0, 32'h7FFF_FFFF, 32'd1, 4'h5, 0, 1, 1);
    run_op("R10", 4'd7, 32'd5, 32'd5, 4'h0, 0, 0, 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      run_op("R2", op, $urandom, $urandom, 4'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_reverse();
    t_overflow();
    t_logic();
    t_shift_carry();
    t_noflags();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule